// File: doc/BRIEF.md
# Card Sleep-Handshake Vendor Register Bank

This block is a small bank of byte-wide vendor registers decoded in the top sixteen addresses (0xF0 to 0xFF) of an SDIO card's common register space. The host reaches it through a plain register read/write port driven by the SDIO command layer. The card side talks to it through a sleep controller port and a firmware port. The bank arbitrates deep sleep: the host writes a sleep-control byte that either lets the card doze or holds it awake. It can also ask for an interrupt once the card reports that it is awake.

Besides the sleep control, the bank carries a host interrupt flag that is cleared by writing a one. It has two scratch bytes passing from the host to the card and two passing from the card to the host. A shadow enable byte lets the host notice when a function has been reset inside the card. A function counts as reset when the standard enable for it is on but its shadow bit is off. Writing the shadow bit again re-enables that function.

Top module: `sdio_sleep_regbank`

## Requirements
- R1: After reset every register reads 0x00, `host_irq`, `wake_req` and `io_reset_flags` are 0, and `sleep_ok` is 1.
- R2: Address 0xF0 holds the sleep-control byte. It reads back as written. Bit 0 drives `wake_req` and bits [7:4] drive `sleep_func`.
- R3: `sleep_ok` is 1 exactly when bits [1:0] of the sleep-control byte are 00. It changes on the same clock edge as the register.
- R4: When the sleep-control byte is written with bits [1:0] = 11 while `card_awake` is 1, `host_irq` goes high on that same write edge.
- R5: With bits [1:0] = 11 in place, a 0-to-1 change on `card_awake` raises `host_irq` on the first edge that samples the 1. With bits [1:0] = 01, the same change raises nothing.
- R6: Writing a byte with bit 0 = 1 to 0xF1 clears the pending interrupt. Writing bit 0 = 0 leaves it unchanged. Reading 0xF1 returns the pending flag in bit 0, with the other bits at 0.
- R7: A one-cycle pulse on `func_int_set` makes the interrupt pending on the next edge.
- R8: 0xF2 and 0xF3 are host read/write bytes. Their values appear on `host_scratch` (0xF2 in bits [7:0], 0xF3 in bits [15:8]).
- R9: 0xF4 and 0xF5 are loaded from `card_scratch_wdata` when `card_scratch_we` bit 0 or bit 1 is set, respectively. Host writes to them are ignored.
- R10: 0xF6 is the host read/write shadow enable byte. `io_reset_flags` equals `std_io_en` AND NOT shadow, and it updates on the edge that loads the shadow byte.
- R11: A pulse on `func_reset[i]` clears shadow bit i. The pulse wins over a host write to 0xF6 in the same cycle.
- R12: Reads of 0xF7 to 0xFF, or of any address below 0xF0, return 0x00. Writes to those addresses change nothing.
- R13: `host_rdata` is loaded on the edge that samples `host_rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| card_awake | input | 1 | Sleep controller status, 1 = awake |
| func_int_set | input | 1 | Card-side pulse that raises the host interrupt |
| card_scratch_we | input | 2 | Card-side write enables for 0xF4/0xF5 |
| card_scratch_wdata | input | 8 | Card-side scratch data |
| std_io_en | input | 8 | Standard per-function I/O enable |
| func_reset | input | 8 | Per-function internal reset pulses |
| sleep_ok | output | 1 | Deep sleep permitted |
| wake_req | output | 1 | Host wake request bit |
| sleep_func | output | 4 | Function number of the sleep request |
| host_irq | output | 1 | Pending host interrupt |
| host_scratch | output | 16 | Host-to-card scratch bytes |
| io_reset_flags | output | 8 | Per-function internal-reset indication |

## Verification
Register writes, `sleep_ok`, `host_irq`, the shadow byte and `io_reset_flags` all change on the edge that samples the write or pulse. The bench drives each stimulus at a falling edge and checks at the next falling edge, so one rising edge lies between them. A read result appears on the edge that samples the read strobe, and it is compared one falling edge later. An awake-status change goes through one edge-detect register, but that register shares the edge that loads the flag, so that result also falls due at the next falling edge. The bench checks the held value of `host_rdata` several idle cycles after a read to confirm R13.

// File: rtl/slpbank_pkg.sv
package slpbank_pkg;
  localparam int BYTE_W  = 8;
  localparam int SCR_CNT = 2;
  localparam logic [3:0] WIN_HI   = 4'hF;
  localparam logic [3:0] OFS_SLP  = 4'h0;
  localparam logic [3:0] OFS_CLR  = 4'h1;
  localparam logic [3:0] OFS_H2C  = 4'h2;
  localparam logic [3:0] OFS_C2H  = 4'h4;
  localparam logic [3:0] OFS_SHD  = 4'h6;
  localparam logic [1:0] MODE_DOZE  = 2'b00;
  localparam logic [1:0] MODE_READY = 2'b11;
endpackage

// File: rtl/slp_state_ctrl.sv
module slp_state_ctrl
  import slpbank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_state,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  input  logic          card_awake,
  input  logic          func_int_set,
  output logic [DW-1:0] state_q,
  output logic          pend_q,
  output logic          sleep_ok_q
);
  logic          awake_q;
  logic [DW-1:0] state_d;
  logic          awake_rise, set_ready, set_any, clr_req, pend_d;

  always_comb begin
    state_d    = wr_state ? wdata : state_q;
    awake_rise = card_awake & ~awake_q;
    set_ready  = (state_d[1:0] == MODE_READY) && ((wr_state && card_awake) || awake_rise);
    set_any    = set_ready | func_int_set;
    clr_req    = wr_clr & wdata[0];
    if (set_any)      pend_d = 1'b1;
    else if (clr_req) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= '0;
      awake_q    <= 1'b0;
      pend_q     <= 1'b0;
      sleep_ok_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      awake_q    <= card_awake;
      pend_q     <= pend_d;
      sleep_ok_q <= (state_d[1:0] == MODE_DOZE);
    end
  end

  // R3: doze permission never coexists with a wake request
  a_r3_no_sleep_when_wake: assert property (@(posedge clk) disable iff (rst)
    state_q[0] |-> !sleep_ok_q);
  // R6: an unopposed clear empties the flag
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !set_any) |=> !pend_q);
  // R5: the flag rises only from the ready mode or a card-side request
  a_r5_irq_source: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !func_int_set && state_d[1:0] != MODE_READY) |=> !pend_q);
endmodule

// File: rtl/slp_scratch_regs.sv
module slp_scratch_regs
  import slpbank_pkg::*;
#(
  parameter int DW = 8,
  parameter int N  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    host_we,
  input  logic [DW-1:0]   host_wdata,
  input  logic [N-1:0]    card_we,
  input  logic [DW-1:0]   card_wdata,
  output logic [N*DW-1:0] h2c_q,
  output logic [N*DW-1:0] c2h_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      h2c_q <= '0;
      c2h_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (host_we[i]) h2c_q[i*DW +: DW] <= host_wdata;
        if (card_we[i]) c2h_q[i*DW +: DW] <= card_wdata;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R9: card-to-host bytes move only on a card-side strobe
    a_r9_c2h_hold: assert property (@(posedge clk) disable iff (rst)
      !card_we[g] |=> $stable(c2h_q[g*DW +: DW]));
    // R8: host bytes move only on a host write
    a_r8_h2c_hold: assert property (@(posedge clk) disable iff (rst)
      !host_we[g] |=> $stable(h2c_q[g*DW +: DW]));
  end
endmodule

// File: rtl/slp_ioen_shadow.sv
module slp_ioen_shadow #(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [NF-1:0] wdata,
  input  logic [NF-1:0] func_reset,
  input  logic [NF-1:0] std_en,
  output logic [NF-1:0] shadow_q,
  output logic [NF-1:0] flags_q
);
  logic [NF-1:0] shadow_d;

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      if (func_reset[i]) shadow_d[i] = 1'b0;
      else if (wr_en)    shadow_d[i] = wdata[i];
      else               shadow_d[i] = shadow_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      flags_q  <= '0;
    end else begin
      shadow_q <= shadow_d;
      flags_q  <= std_en & ~shadow_d;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_chk
    // R11: a function reset always wins
    a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
      func_reset[g] |=> !shadow_q[g]);
  end
endmodule

// File: rtl/sdio_sleep_regbank.sv
module sdio_sleep_regbank
  import slpbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NFUNC  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      host_wr_en,
  input  logic                      host_rd_en,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [DATA_W-1:0]         host_wdata,
  output logic [DATA_W-1:0]         host_rdata,
  input  logic                      card_awake,
  input  logic                      func_int_set,
  input  logic [SCR_CNT-1:0]        card_scratch_we,
  input  logic [DATA_W-1:0]         card_scratch_wdata,
  input  logic [NFUNC-1:0]          std_io_en,
  input  logic [NFUNC-1:0]          func_reset,
  output logic                      sleep_ok,
  output logic                      wake_req,
  output logic [3:0]                sleep_func,
  output logic                      host_irq,
  output logic [SCR_CNT*DATA_W-1:0] host_scratch,
  output logic [NFUNC-1:0]          io_reset_flags
);
  localparam int SCR_BITS = SCR_CNT * DATA_W;

  logic              in_win;
  logic [3:0]        ofs;
  logic              wr_slp, wr_clr, wr_shd;
  logic [SCR_CNT-1:0] wr_h2c;
  logic [DATA_W-1:0] state_q, shadow_byte, rd_mux;
  logic              pend_q;
  logic [SCR_BITS-1:0] h2c_q, c2h_q;
  logic [NFUNC-1:0]  shadow_q;

  assign in_win = (host_addr[ADDR_W-1:4] == {(ADDR_W-4){1'b1}}) && (WIN_HI == 4'hF);
  assign ofs    = host_addr[3:0];
  assign wr_slp = host_wr_en && in_win && (ofs == OFS_SLP);
  assign wr_clr = host_wr_en && in_win && (ofs == OFS_CLR);
  assign wr_shd = host_wr_en && in_win && (ofs == OFS_SHD);

  for (genvar g = 0; g < SCR_CNT; g++) begin : g_dec
    assign wr_h2c[g] = host_wr_en && in_win && (ofs == OFS_H2C + 4'(g));
  end

  slp_state_ctrl #(.DW(DATA_W)) u_state (
    .clk(clk), .rst(rst), .wr_state(wr_slp), .wr_clr(wr_clr), .wdata(host_wdata),
    .card_awake(card_awake), .func_int_set(func_int_set),
    .state_q(state_q), .pend_q(pend_q), .sleep_ok_q(sleep_ok)
  );

  slp_scratch_regs #(.DW(DATA_W), .N(SCR_CNT)) u_scr (
    .clk(clk), .rst(rst), .host_we(wr_h2c), .host_wdata(host_wdata),
    .card_we(card_scratch_we), .card_wdata(card_scratch_wdata),
    .h2c_q(h2c_q), .c2h_q(c2h_q)
  );

  slp_ioen_shadow #(.NF(NFUNC)) u_shd (
    .clk(clk), .rst(rst), .wr_en(wr_shd), .wdata(host_wdata[NFUNC-1:0]),
    .func_reset(func_reset), .std_en(std_io_en),
    .shadow_q(shadow_q), .flags_q(io_reset_flags)
  );

  assign shadow_byte  = DATA_W'(shadow_q);
  assign wake_req     = state_q[0];
  assign sleep_func   = state_q[7:4];
  assign host_irq     = pend_q;
  assign host_scratch = h2c_q;

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      if (ofs == OFS_SLP) rd_mux = state_q;
      if (ofs == OFS_CLR) rd_mux = DATA_W'(pend_q);
      if (ofs == OFS_SHD) rd_mux = shadow_byte;
      for (int i = 0; i < SCR_CNT; i++) begin
        if (ofs == OFS_H2C + 4'(i)) rd_mux = h2c_q[i*DATA_W +: DATA_W];
        if (ofs == OFS_C2H + 4'(i)) rd_mux = c2h_q[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             host_rdata <= '0;
    else if (host_rd_en) host_rdata <= rd_mux;
  end

  // R12: reads outside the implemented offsets return zero
  a_r12_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && (!in_win || ofs > OFS_SHD)) |=> (host_rdata == '0));
  // R13: read data holds between reads
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd_en |=> $stable(host_rdata));
endmodule

// File: tb/sdio_sleep_regbank_bench.sv
module sdio_sleep_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 0, host_rd_en = 0;
  logic [7:0]  host_addr = 0, host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        card_awake = 0, func_int_set = 0;
  logic [1:0]  card_scratch_we = 0;
  logic [7:0]  card_scratch_wdata = 0;
  logic [7:0]  std_io_en = 0, func_reset = 0;
  logic        sleep_ok, wake_req, host_irq;
  logic [3:0]  sleep_func;
  logic [15:0] host_scratch;
  logic [7:0]  io_reset_flags;

  int n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  sdio_sleep_regbank u_sdio_sleep_regbank (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .card_awake(card_awake), .func_int_set(func_int_set),
    .card_scratch_we(card_scratch_we), .card_scratch_wdata(card_scratch_wdata),
    .std_io_en(std_io_en), .func_reset(func_reset), .sleep_ok(sleep_ok),
    .wake_req(wake_req), .sleep_func(sleep_func), .host_irq(host_irq),
    .host_scratch(host_scratch), .io_reset_flags(io_reset_flags)
  );

  // {write, addr, data, expected read, requirement number}
  localparam int NV = 20;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'hF2, 8'hA5, 8'h00, 4'd8},  // R8
    {1'b0, 8'hF2, 8'h00, 8'hA5, 4'd8},
    {1'b1, 8'hF3, 8'h3C, 8'h00, 4'd8},
    {1'b0, 8'hF3, 8'h00, 8'h3C, 4'd8},
    {1'b1, 8'hF4, 8'hFF, 8'h00, 4'd9},  // R9
    {1'b0, 8'hF4, 8'h00, 8'h00, 4'd9},
    {1'b1, 8'hF5, 8'h81, 8'h00, 4'd9},
    {1'b0, 8'hF5, 8'h00, 8'h00, 4'd9},
    {1'b1, 8'hF6, 8'h0E, 8'h00, 4'd10}, // R10
    {1'b0, 8'hF6, 8'h00, 8'h0E, 4'd10},
    {1'b1, 8'hF7, 8'h77, 8'h00, 4'd12}, // R12
    {1'b0, 8'hF7, 8'h00, 8'h00, 4'd12},
    {1'b1, 8'hFF, 8'h5A, 8'h00, 4'd12},
    {1'b0, 8'hFF, 8'h00, 8'h00, 4'd12},
    {1'b1, 8'h12, 8'h55, 8'h00, 4'd12},
    {1'b0, 8'h12, 8'h00, 8'h00, 4'd12},
    {1'b1, 8'hF0, 8'h41, 8'h00, 4'd2},  // R2
    {1'b0, 8'hF0, 8'h00, 8'h41, 4'd2},
    {1'b1, 8'hF0, 8'h00, 8'h00, 4'd2},
    {1'b0, 8'hF1, 8'h00, 8'h00, 4'd6}   // R6
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    host_wr_en = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic hread(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd_en = 1; host_addr = a;
    @(negedge clk);
    host_rd_en = 0;
    d = host_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", {host_irq, wake_req, sleep_ok}, 3'b001);
    check("R1", {host_scratch, io_reset_flags, host_rdata}, 32'h0);
    hread(8'hF0, rv); check("R1", rv, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) hwrite(VEC[i][27:20], VEC[i][19:12]);
      else begin
        hread(VEC[i][27:20], rv);
        n_chk++;
        if (rv !== VEC[i][11:4]) begin
          n_fail++;
          $display("FAIL R%0d addr=%0h actual=%0h expected=%0h",
                   VEC[i][3:0], VEC[i][27:20], rv, VEC[i][11:4]);
        end
      end
    end
    check("R8", host_scratch, 16'h3CA5);

    // R2/R3 sleep control outputs
    hwrite(8'hF0, 8'h31);
    check("R3", sleep_ok, 1'b0);
    check("R2", {wake_req, sleep_func}, {1'b1, 4'h3});
    hwrite(8'hF0, 8'h70);
    check("R3", sleep_ok, 1'b1);

    // R4 immediate ready interrupt
    card_awake = 1;
    @(negedge clk);
    hwrite(8'hF0, 8'h13);
    check("R4", host_irq, 1'b1);
    hread(8'hF1, rv); check("R6", rv, 8'h01);
    hwrite(8'hF1, 8'hFE);
    check("R6", host_irq, 1'b1);
    hwrite(8'hF1, 8'h01);
    check("R6", host_irq, 1'b0);

    // R5 interrupt on awake rise
    card_awake = 0;
    hwrite(8'hF0, 8'h03);
    check("R5", host_irq, 1'b0);
    @(negedge clk); card_awake = 1;
    @(negedge clk);
    check("R5", host_irq, 1'b1);
    hwrite(8'hF1, 8'h01);
    card_awake = 0;
    hwrite(8'hF0, 8'h01);
    @(negedge clk); card_awake = 1;
    repeat (2) @(negedge clk);
    check("R5", host_irq, 1'b0);

    // R7 card-side interrupt request
    func_int_set = 1;
    @(negedge clk); func_int_set = 0;
    check("R7", host_irq, 1'b1);
    hwrite(8'hF1, 8'h01);

    // R9 card-side scratch load, host write ignored
    card_scratch_we = 2'b01; card_scratch_wdata = 8'h5A;
    @(negedge clk); card_scratch_we = 0;
    hwrite(8'hF4, 8'h11);
    hread(8'hF4, rv); check("R9", rv, 8'h5A);

    // R13 read data held
    hwrite(8'hF2, 8'h99);
    repeat (3) @(negedge clk);
    check("R13", host_rdata, 8'h5A);

    // R10 shadow enable vs standard enable
    std_io_en = 8'h0E;
    repeat (2) @(negedge clk);
    check("R10", io_reset_flags, 8'h00);
    hwrite(8'hF6, 8'h0A);
    check("R10", io_reset_flags, 8'h04);

    // R11 function reset pulses
    @(negedge clk); func_reset = 8'h08;
    @(negedge clk); func_reset = 0;
    check("R11", io_reset_flags, 8'h0C);
    hread(8'hF6, rv); check("R11", rv, 8'h02);
    @(negedge clk);
    host_wr_en = 1; host_addr = 8'hF6; host_wdata = 8'hFF; func_reset = 8'h01;
    @(negedge clk);
    host_wr_en = 0; func_reset = 0;
    hread(8'hF6, rv); check("R11", rv, 8'hFE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule